// File: doc/BRIEF.md
# Burst SRAM cycle controller

A synchronous, pipelined word memory with a two-bit linear burst counter in front of it. On every rising clock edge the block samples three chip enables, two start strobes (one for a processor, one for a memory controller), a burst-step input, a write-all input, a byte-write gate, one write strobe per byte lane, the address and the write data. From these it picks the kind of cycle: a new read or write, a continuation that steps the burst address, a hold that reuses the present address, or no access at all.

Each cycle takes its address from one of three places: the address port, the next address in the burst, or the address already held. A begun burst stays live until a strobe cycle deselects the block. Read data leaves the array through an output register. The read-data drive enable is gated combinationally by an output-enable input that is never clocked. The data bus is split into an input, an output and a drive enable. A pad ring outside the block merges them into one three-state bus.

Top module: `burst_sram_ctrl`

## Requirements
- R1: While reset is asserted, and afterwards until the first read, `dout_en` is 0 and no burst is live, so cycles without a strobe do nothing.
- R2: A processor start (`start_proc_n` low with `ce_pri_n` low), or a controller start (`start_ctl_n` low with `ce_pri_n` low), on a cycle where `ce_hi` is 1 and `ce_lo_n` is 0, loads `addr` into the address register and begins a burst. When both strobes qualify, the processor start wins.
- R3: With no qualifying strobe, a live burst and `burst_step_n` low, the cycle uses the next burst address. The two low address bits count up modulo 4 and the upper bits stay unchanged. The orders are 0,1,2,3 / 1,2,3,0 / 2,3,0,1 / 3,0,1,2.
- R4: With no qualifying strobe, a live burst and `burst_step_n` high, the address is held. A read is repeated at the same address and the bus stays driven. A write goes to the same address.
- R5: A processor start with `ce_hi` 0 or `ce_lo_n` 1 is unselected. So is a controller start with any chip enable inactive. Either one ends the burst, and `dout_en` is 0 two edges later.
- R6: Lane i is data bits 8i+7..8i. With `wr_all_n` low, all four lanes are written. Otherwise, with `wr_byte_en_n` low, lane i is written when `byte_wr_n[i]` is 0. A cycle that writes no lane is a read.
- R7: A processor start is always a read. The write inputs in that cycle change no memory.
- R8: `start_proc_n` low with `ce_pri_n` high is ignored. The cycle is decoded from the other inputs as a continue or hold.
- R9: `dout_en` is 1 exactly when the registered read data is valid and `out_en_n` is 0. It follows `out_en_n` with no clock edge in between.
- R10: The address of a read is registered at edge k. The word read from memory before any write at edge k+1 is on `dout`, with `dout_en` valid, from edge k+1 until edge k+2.
- R11: When no burst is live, a cycle without a qualifying strobe writes nothing and starts no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_pri_n | input | 1 | Primary chip enable, active low, qualifies the processor start |
| ce_hi | input | 1 | Chip enable, active high |
| ce_lo_n | input | 1 | Chip enable, active low |
| start_proc_n | input | 1 | Processor-side start strobe, active low |
| start_ctl_n | input | 1 | Controller-side start strobe, active low |
| burst_step_n | input | 1 | Step the burst address when low, hold when high |
| wr_all_n | input | 1 | Write all lanes when low |
| wr_byte_en_n | input | 1 | Gate for the per-lane write strobes, active low |
| byte_wr_n | input | 4 | Per-lane write strobes, active low |
| addr | input | ADDR_W | Word address |
| din | input | 32 | Write data |
| out_en_n | input | 1 | Output enable, active low, not clocked |
| dout | output | 32 | Registered read data |
| dout_en | output | 1 | Drive enable for the external data bus |

## Verification
Bursts are started at each of the four low-bit offsets, so every wrap order (R3) is seen in the returned data. The memory is filled with a distinct word at every address, so a wrong step or a missing wrap shows up as a wrong word. A burst that is held twice in the middle tells a held address apart from a stepped one. Controller writes with lane patterns such as 1010, none and all, followed by readback, separate the write-all path, the byte-gated path and the write-nothing-means-read case. Strobes with each enable inactive, a processor start carrying write inputs, a processor start with the primary enable off, and steps with no live burst each show whether the decoder picks the right address source or no access. Toggling `out_en_n` between clock edges shows that the drive enable is not registered.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

  typedef enum logic [2:0] {
    CYC_NONE,
    CYC_BEGIN_RD,
    CYC_BEGIN_WR,
    CYC_CONT_RD,
    CYC_CONT_WR,
    CYC_HOLD_RD,
    CYC_HOLD_WR
  } cyc_kind_e;

  typedef enum logic [1:0] {
    SRC_NONE,
    SRC_EXT,
    SRC_NEXT,
    SRC_CUR
  } addr_src_e;

  function automatic logic cyc_reads(input cyc_kind_e k);
    return (k == CYC_BEGIN_RD) || (k == CYC_CONT_RD) || (k == CYC_HOLD_RD);
  endfunction

endpackage

// File: rtl/bsc_cycle_decode.sv
module bsc_cycle_decode
  import bsc_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             ce_pri_n,
  input  logic             ce_hi,
  input  logic             ce_lo_n,
  input  logic             start_proc_n,
  input  logic             start_ctl_n,
  input  logic             burst_step_n,
  input  logic             wr_all_n,
  input  logic             wr_byte_en_n,
  input  logic [LANES-1:0] byte_wr_n,
  input  logic             burst_live,
  output cyc_kind_e        kind,
  output addr_src_e        src,
  output logic [LANES-1:0] lane_we,
  output logic             live_set,
  output logic             live_clr
);

  logic [LANES-1:0] lane_req;
  logic             wants_wr;
  logic             chip_on;
  logic             proc_hit;
  logic             ctl_hit;

  // Lane request from the write inputs; write-all overrides the byte gate.
  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      if (!wr_all_n) begin
        lane_req[i] = 1'b1;
      end else begin
        lane_req[i] = !wr_byte_en_n && !byte_wr_n[i];
      end
    end
  end

  assign wants_wr = |lane_req;
  assign chip_on  = ce_hi && !ce_lo_n;
  assign proc_hit = !start_proc_n && !ce_pri_n;
  assign ctl_hit  = !start_ctl_n;

  always_comb begin
    kind     = CYC_NONE;
    src      = SRC_NONE;
    lane_we  = '0;
    live_set = 1'b0;
    live_clr = 1'b0;
    if (proc_hit) begin
      if (chip_on) begin
        kind     = CYC_BEGIN_RD;
        src      = SRC_EXT;
        live_set = 1'b1;
      end else begin
        live_clr = 1'b1;
      end
    end else if (ctl_hit) begin
      if (chip_on && !ce_pri_n) begin
        src      = SRC_EXT;
        live_set = 1'b1;
        if (wants_wr) begin
          kind    = CYC_BEGIN_WR;
          lane_we = lane_req;
        end else begin
          kind = CYC_BEGIN_RD;
        end
      end else begin
        live_clr = 1'b1;
      end
    end else if (burst_live) begin
      if (!burst_step_n) begin
        src  = SRC_NEXT;
        kind = wants_wr ? CYC_CONT_WR : CYC_CONT_RD;
      end else begin
        src  = SRC_CUR;
        kind = wants_wr ? CYC_HOLD_WR : CYC_HOLD_RD;
      end
      lane_we = lane_req;
    end
  end

endmodule

// File: rtl/bsc_burst_addr.sv
module bsc_burst_addr
  import bsc_pkg::*;
#(
  parameter int AW      = 8,
  parameter int BURST_W = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  addr_src_e     src,
  input  logic [AW-1:0] ext_addr,
  input  logic          live_set,
  input  logic          live_clr,
  output logic [AW-1:0] eff_addr,
  output logic [AW-1:0] addr_q,
  output logic          live_q
);

  logic [BURST_W-1:0] wrap_nxt;
  logic [AW-1:0]      addr_d;
  logic               addr_en;
  logic               live_d;

  assign wrap_nxt = addr_q[BURST_W-1:0] + 1'b1;

  always_comb begin
    case (src)
      SRC_EXT:  eff_addr = ext_addr;
      SRC_NEXT: eff_addr = {addr_q[AW-1:BURST_W], wrap_nxt};
      default:  eff_addr = addr_q;
    endcase
  end

  assign addr_en = (src != SRC_NONE);
  assign addr_d  = eff_addr;

  always_comb begin
    live_d = live_q;
    if (live_set) begin
      live_d = 1'b1;
    end else if (live_clr) begin
      live_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      live_q <= 1'b0;
    end else begin
      if (addr_en) begin
        addr_q <= addr_d;
      end
      live_q <= live_d;
    end
  end

endmodule

// File: rtl/bsc_word_array.sv
module bsc_word_array #(
  parameter int AW     = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic [AW-1:0]           wr_addr,
  input  logic [LANES-1:0]        lane_we,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic                    rd_en,
  input  logic [AW-1:0]           rd_addr,
  output logic [LANES*LANE_W-1:0] rd_data
);

  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];
    logic [LANE_W-1:0] lane_q;

    always_ff @(posedge clk) begin
      if (lane_we[g]) begin
        cells[wr_addr] <= wdata[g*LANE_W +: LANE_W];
      end
      if (rd_en) begin
        lane_q <= cells[rd_addr];
      end
    end

    assign rd_data[g*LANE_W +: LANE_W] = lane_q;
  end

endmodule

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
  import bsc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  parameter int BURST_W = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ce_pri_n,
  input  logic                    ce_hi,
  input  logic                    ce_lo_n,
  input  logic                    start_proc_n,
  input  logic                    start_ctl_n,
  input  logic                    burst_step_n,
  input  logic                    wr_all_n,
  input  logic                    wr_byte_en_n,
  input  logic [LANES-1:0]        byte_wr_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES*LANE_W-1:0] din,
  input  logic                    out_en_n,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    dout_en
);

  localparam int DATA_W = LANES * LANE_W;

  // Reset: asserted asynchronously, released on a clock edge.
  logic rst_meta_q;
  logic rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  cyc_kind_e          kind;
  addr_src_e          src;
  logic [LANES-1:0]   lane_we;
  logic               live_set;
  logic               live_clr;
  logic               live_q;
  logic [ADDR_W-1:0]  eff_addr;
  logic [ADDR_W-1:0]  addr_q;
  logic [DATA_W-1:0]  rd_data;

  bsc_cycle_decode #(.LANES(LANES)) u_decode (
    .ce_pri_n     (ce_pri_n),
    .ce_hi        (ce_hi),
    .ce_lo_n      (ce_lo_n),
    .start_proc_n (start_proc_n),
    .start_ctl_n  (start_ctl_n),
    .burst_step_n (burst_step_n),
    .wr_all_n     (wr_all_n),
    .wr_byte_en_n (wr_byte_en_n),
    .byte_wr_n    (byte_wr_n),
    .burst_live   (live_q),
    .kind         (kind),
    .src          (src),
    .lane_we      (lane_we),
    .live_set     (live_set),
    .live_clr     (live_clr)
  );

  bsc_burst_addr #(.AW(ADDR_W), .BURST_W(BURST_W)) u_addr (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .src      (src),
    .ext_addr (addr),
    .live_set (live_set),
    .live_clr (live_clr),
    .eff_addr (eff_addr),
    .addr_q   (addr_q),
    .live_q   (live_q)
  );

  // Read pipeline: pending read registered with the address, valid one edge later.
  logic rd_pend_d;
  logic rd_pend_q;
  logic vld_q;

  assign rd_pend_d = cyc_reads(kind);

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rd_pend_q <= 1'b0;
      vld_q     <= 1'b0;
    end else begin
      rd_pend_q <= rd_pend_d;
      vld_q     <= rd_pend_q;
    end
  end

  bsc_word_array #(.AW(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk     (clk),
    .wr_addr (eff_addr),
    .lane_we (lane_we),
    .wdata   (din),
    .rd_en   (rd_pend_q),
    .rd_addr (addr_q),
    .rd_data (rd_data)
  );

  assign dout    = rd_data;
  assign dout_en = vld_q && !out_en_n;

endmodule

// File: rtl/bsc_checker.sv
module bsc_checker #(
  parameter int AW    = 8,
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ce_pri_n,
  input logic             ce_hi,
  input logic             ce_lo_n,
  input logic             start_proc_n,
  input logic             start_ctl_n,
  input logic             burst_step_n,
  input logic [AW-1:0]    addr,
  input logic [AW-1:0]    addr_q,
  input logic             live_q,
  input logic [LANES-1:0] lane_we,
  input logic             dout_en
);

  logic chip_on;
  logic proc_hit;
  logic no_strobe;

  assign chip_on   = ce_hi && !ce_lo_n;
  assign proc_hit  = !start_proc_n && !ce_pri_n;
  assign no_strobe = (start_proc_n || ce_pri_n) && start_ctl_n;

  assert_begin_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_hit && chip_on) |=> (addr_q == $past(addr)));

  assert_linear_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (no_strobe && !burst_step_n && live_q) |=>
      ((addr_q[1:0] == 2'($past(addr_q[1:0]) + 2'd1)) &&
       (addr_q[AW-1:2] == $past(addr_q[AW-1:2]))));

  assert_hold_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (no_strobe && burst_step_n) |=> $stable(addr_q));

  assert_deselect_float_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (proc_hit && !chip_on) |-> ##2 !dout_en);

  assert_proc_reads_R7: assert property (@(posedge clk) disable iff (!rst_n)
    proc_hit |-> (lane_we == '0));

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (no_strobe && !live_q) |-> (lane_we == '0));

endmodule

bind burst_sram_ctrl bsc_checker #(.AW(ADDR_W), .LANES(LANES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .ce_pri_n     (ce_pri_n),
  .ce_hi        (ce_hi),
  .ce_lo_n      (ce_lo_n),
  .start_proc_n (start_proc_n),
  .start_ctl_n  (start_ctl_n),
  .burst_step_n (burst_step_n),
  .addr         (addr),
  .addr_q       (addr_q),
  .live_q       (live_q),
  .lane_we      (lane_we),
  .dout_en      (dout_en)
);

// File: tb/burst_sram_ctrl_test.sv
module burst_sram_ctrl_test;

  localparam int AW = 8;

  logic        clk;
  logic        rst_n;
  logic        ce_pri_n, ce_hi, ce_lo_n;
  logic        start_proc_n, start_ctl_n, burst_step_n;
  logic        wr_all_n, wr_byte_en_n;
  logic [3:0]  byte_wr_n;
  logic [AW-1:0] addr;
  logic [31:0] din;
  logic        out_en_n;
  logic [31:0] dout;
  logic        dout_en;

  burst_sram_ctrl #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .ce_pri_n(ce_pri_n), .ce_hi(ce_hi), .ce_lo_n(ce_lo_n),
    .start_proc_n(start_proc_n), .start_ctl_n(start_ctl_n), .burst_step_n(burst_step_n),
    .wr_all_n(wr_all_n), .wr_byte_en_n(wr_byte_en_n), .byte_wr_n(byte_wr_n),
    .addr(addr), .din(din), .out_en_n(out_en_n), .dout(dout), .dout_en(dout_en)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int    checks = 0;
  int    errors = 0;
  bit    done   = 0;
  string cur_req = "R1";

  // Reference model state
  logic [31:0]   ref_mem [1 << AW];
  logic [AW-1:0] m_addr  = '0;
  bit            m_live  = 0;
  bit            m_rdpend = 0;
  bit            m_vld   = 0;
  logic [31:0]   m_dout  = '0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_bus();
    bit exp_en;
    exp_en = m_vld && !out_en_n;
    chk(dout_en == exp_en, cur_req, {31'd0, dout_en}, {31'd0, exp_en});
    if (exp_en) chk(dout == m_dout, cur_req, dout, m_dout);
  endtask

  // One clock: apply inputs, advance the model, check after the edge.
  task automatic drive(input bit p_n, input bit c_n, input bit s_n, input bit pri_n,
                       input bit hi, input bit lo_n, input bit ga_n, input bit be_n,
                       input logic [3:0] bw, input logic [AW-1:0] a, input logic [31:0] d);
    bit            nv, rd, wr, chip;
    logic [31:0]   nd;
    logic [3:0]    lanes;
    int            srcsel;
    logic [AW-1:0] eff;
    start_proc_n = p_n; start_ctl_n = c_n; burst_step_n = s_n; ce_pri_n = pri_n;
    ce_hi = hi; ce_lo_n = lo_n; wr_all_n = ga_n; wr_byte_en_n = be_n; byte_wr_n = bw;
    addr = a; din = d;
    nv = m_rdpend;
    nd = ref_mem[m_addr];
    lanes = !ga_n ? 4'hf : (!be_n ? ~bw : 4'h0);
    chip = hi && !lo_n;
    rd = 0; wr = 0; srcsel = 0;
    if (!p_n && !pri_n) begin
      if (chip) begin srcsel = 1; rd = 1; m_live = 1; end
      else m_live = 0;
    end else if (!c_n) begin
      if (chip && !pri_n) begin
        srcsel = 1; wr = (lanes != 0); rd = !wr; m_live = 1;
      end else m_live = 0;
    end else if (m_live) begin
      srcsel = s_n ? 3 : 2; wr = (lanes != 0); rd = !wr;
    end
    case (srcsel)
      1: eff = a;
      2: eff = {m_addr[AW-1:2], 2'(m_addr[1:0] + 2'd1)};
      default: eff = m_addr;
    endcase
    if (wr) begin
      for (int i = 0; i < 4; i++)
        if (lanes[i]) ref_mem[eff][i*8 +: 8] = d[i*8 +: 8];
    end
    if (srcsel != 0) m_addr = eff;
    m_rdpend = rd;
    m_vld = nv;
    m_dout = nd;
    @(posedge clk);
    @(negedge clk);
    compare_bus();
  endtask

  task automatic proc_rd(input logic [AW-1:0] a);
    drive(0, 1, 1, 0, 1, 0, 1, 1, 4'hf, a, 32'h0);
  endtask
  task automatic ctl_rd(input logic [AW-1:0] a);
    drive(1, 0, 1, 0, 1, 0, 1, 1, 4'hf, a, 32'h0);
  endtask
  task automatic ctl_wr(input logic [AW-1:0] a, input logic [31:0] d, input bit ga_n,
                        input bit be_n, input logic [3:0] bw);
    drive(1, 0, 1, 0, 1, 0, ga_n, be_n, bw, a, d);
  endtask
  task automatic step(input bit s_n, input bit ga_n, input bit be_n, input logic [3:0] bw,
                      input logic [31:0] d);
    drive(1, 1, s_n, 0, 1, 0, ga_n, be_n, bw, '0, d);
  endtask
  task automatic step_rd(input bit s_n);
    step(s_n, 1, 1, 4'hf, 32'h0);
  endtask
  task automatic desel();
    drive(1, 0, 1, 1, 1, 0, 1, 1, 4'hf, '0, 32'h0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog %s actual=%h expected=%h", cur_req, 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    for (int i = 0; i < (1 << AW); i++) ref_mem[i] = '0;
    start_proc_n = 1; start_ctl_n = 1; burst_step_n = 1; ce_pri_n = 0; ce_hi = 1;
    ce_lo_n = 0; wr_all_n = 1; wr_byte_en_n = 1; byte_wr_n = 4'hf; addr = '0;
    din = '0; out_en_n = 0;
    rst_n = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    cur_req = "R1";
    chk(dout_en == 1'b0, "R1", {31'd0, dout_en}, 32'd0);
    rst_n = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(dout_en == 1'b0, "R1", {31'd0, dout_en}, 32'd0);
    step_rd(0);
    step_rd(1);

    // Fill with distinct words using write-all
    cur_req = "R6";
    for (int i = 0; i < (1 << AW); i++)
      ctl_wr(AW'(i), {8'hA5, 8'(i), 8'(~i), 8'(i ^ 8'h3c)}, 0, 1, 4'hf);
    desel();

    // Four wrap orders
    cur_req = "R3";
    for (int s = 0; s < 4; s++) begin
      proc_rd(AW'(8'h40 + s));
      for (int k = 0; k < 3; k++) step_rd(0);
      step_rd(1);
      desel();
      desel();
    end

    // Latency and controller-started read
    cur_req = "R10";
    ctl_rd(8'h33);
    step_rd(1);
    desel();
    desel();

    // Hold in the middle of a burst
    cur_req = "R4";
    proc_rd(8'h82);
    step_rd(0);
    step_rd(1);
    step_rd(1);
    step_rd(0);
    step_rd(0);
    desel();
    desel();

    // Byte-gated writes and no-lane cycles that become reads
    cur_req = "R6";
    ctl_wr(8'h10, 32'h11223344, 1, 0, 4'b1010);
    ctl_wr(8'h11, 32'h55667788, 1, 0, 4'b1111);
    ctl_wr(8'h12, 32'h99aabbcc, 1, 1, 4'b0000);
    ctl_wr(8'h21, 32'hdeadbeef, 1, 0, 4'b0000);
    step(0, 1, 0, 4'b0000, 32'h01020304);
    step(0, 1, 0, 4'b0110, 32'hf0e0d0c0);
    step(0, 0, 1, 4'hf, 32'h0badcafe);
    step(1, 1, 0, 4'b1100, 32'h77770000);
    desel();
    proc_rd(8'h10);
    step_rd(0); step_rd(0); step_rd(0); step_rd(1);
    desel();
    proc_rd(8'h20);
    step_rd(0); step_rd(0); step_rd(0); step_rd(1);
    desel();
    desel();

    // Processor start with write inputs, and priority over controller start
    cur_req = "R7";
    drive(0, 1, 1, 0, 1, 0, 0, 0, 4'h0, 8'h30, 32'hffffffff);
    drive(0, 0, 1, 0, 1, 0, 0, 0, 4'h0, 8'h31, 32'heeeeeeee);
    step_rd(1);
    desel();
    proc_rd(8'h30);
    step_rd(0);
    step_rd(1);
    desel();
    desel();

    // Processor start ignored without primary enable
    cur_req = "R8";
    proc_rd(8'h50);
    drive(0, 1, 0, 1, 1, 0, 1, 1, 4'hf, 8'h99, 32'h0);
    drive(0, 1, 1, 1, 1, 0, 1, 1, 4'hf, 8'h99, 32'h0);
    step_rd(0);
    desel();
    desel();

    // Deselect on strobe cycles
    cur_req = "R5";
    proc_rd(8'h60);
    step_rd(0);
    drive(0, 1, 1, 0, 0, 0, 1, 1, 4'hf, 8'h61, 32'h0);
    step_rd(0);
    step_rd(0);
    ctl_rd(8'h62);
    drive(1, 0, 1, 0, 1, 1, 1, 1, 4'hf, 8'h63, 32'h0);
    step_rd(1);
    step_rd(1);

    // No live burst: steps and holds do nothing
    cur_req = "R11";
    step(0, 0, 1, 4'hf, 32'h12345678);
    step(1, 0, 1, 4'hf, 32'h12345678);
    proc_rd(8'h62);
    step_rd(1);
    desel();
    desel();

    // Output enable is not clocked
    cur_req = "R9";
    proc_rd(8'h70);
    step_rd(1);
    out_en_n = 1;
    #1;
    chk(dout_en == 1'b0, "R9", {31'd0, dout_en}, 32'd0);
    out_en_n = 0;
    #1;
    chk(dout_en == 1'b1, "R9", {31'd0, dout_en}, 32'd1);
    chk(dout == ref_mem[8'h70], "R9", dout, ref_mem[8'h70]);
    out_en_n = 1;
    step_rd(0);
    out_en_n = 0;
    #1;
    compare_bus();
    step_rd(0);
    desel();
    desel();

    finish_run();
  end

endmodule